// File: doc/BRIEF.md
# CAN Operating-Mode Manager

This block sits between a CAN protocol engine and the transmit and receive pins and decides, frame by frame, how the controller behaves. Four modes are handled. Silent monitoring keeps the transmit pin recessive, freezes the error counters and passes on only those frames that another node acknowledged. Self-test loop-back feeds the engine's own bitstream back to its receiver, and the engine then accepts its own frames. Module-off gates the clock enables of the protocol and buffer sub-blocks. Chip-level stop parks the block and then acknowledges the stop.

The engine supplies its transmit bit, a frame-end strobe, a bus-idle level, an ACK-slot strobe and receive-done and transmit-done strobes. The block returns the bit the engine should receive, ACK handling and error-counter qualifiers, qualified interrupt pulses, clock enables and the acknowledges for disable and stop. Configuration bits and low-power requests only take effect at a frame boundary. Stop can be left by removing the request or, when self-wake is on, by a filtered dominant level on the bus.

Top module: `can_mode_ctrl`

## Requirements
- R1: With silent mode active and loop-back inactive, `can_tx_pin` is 1 whatever `eng_tx_bit` is, `err_freeze` and `err_passive` are 1, and `eng_tx_ok` produces no `tx_done_irq`.
- R2: In silent mode, an `eng_rx_ok` strobe gives `rx_valid_irq`=1 one cycle later if the synchronized receive level was 0 (dominant) at the last `eng_ack_slot` strobe. If that level was 1 (recessive), it gives `bit0_err`=1 instead and `rx_valid_irq` stays 0.
- R3: With loop-back active, `eng_rx_bit` equals `eng_tx_bit` in the same cycle, the level on `can_rx_pin` has no effect, `can_tx_pin` is 1 and `ack_ignore` is 1.
- R4: In loop-back mode, `eng_rx_ok` and `eng_tx_ok` produce `rx_valid_irq` and `tx_done_irq` one cycle later, whatever the ACK-slot level was.
- R5: In normal mode, `can_tx_pin` follows `eng_tx_bit` combinationally. `eng_rx_bit` follows `can_rx_pin` through a two-flop synchronizer, so it is valid two clock edges after a pin change. `err_freeze` and `ack_ignore` are 0.
- R6: `cfg_disable` sampled at a boundary clears `pe_clk_en` and `mb_clk_en` and sets `dis_ack` from the next cycle. Once `cfg_disable` is cleared, all three return one cycle later.
- R7: `stop_req` sampled at a boundary clears both clock enables one cycle later, and `stop_ack` rises one cycle after that. Dropping `stop_req` in stop restores the clocks and clears `stop_ack` one cycle later.
- R8: In stop with `wake_en`=1, a receive level of 0 held for at least 3 consecutive synchronized samples ends stop. A shorter dominant pulse does not end stop, and neither does any pulse when `wake_en`=0.
- R9: After a wake-up, a `stop_req` that is still high does not put the block back into stop until the request has been dropped and raised again.
- R10: The mode bits, `cfg_disable` and `stop_req` are sampled only in a cycle with `eng_bus_idle` or `eng_frame_end` high. A change made while a frame is in progress has no effect until then.
- R11: When silent and loop-back are both set, loop-back applies: `err_freeze` is 0 and `can_tx_pin` is 1. While the clocks are gated, `can_tx_pin` is 1 whatever the mode bits are.
- R12: After reset both clock enables are 1, `dis_ack`, `stop_ack`, `rx_valid_irq`, `tx_done_irq` and `bit0_err` are 0, and the block is in normal mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_listen | input | 1 | Silent monitoring request |
| cfg_loop | input | 1 | Self-test loop-back request |
| cfg_disable | input | 1 | Module-off request |
| stop_req | input | 1 | Chip-level stop request |
| wake_en | input | 1 | Allow bus activity to end stop |
| eng_tx_bit | input | 1 | Engine transmit bitstream |
| eng_frame_end | input | 1 | Engine frame-end strobe |
| eng_bus_idle | input | 1 | Engine reports an idle bus |
| eng_ack_slot | input | 1 | Strobe in the ACK slot bit |
| eng_rx_ok | input | 1 | Engine finished receiving a frame |
| eng_tx_ok | input | 1 | Engine finished sending a frame |
| can_rx_pin | input | 1 | External receive pin |
| can_tx_pin | output | 1 | External transmit pin |
| eng_rx_bit | output | 1 | Receive bit handed to the engine |
| ack_ignore | output | 1 | Engine ignores the ACK-slot level |
| err_freeze | output | 1 | Hold both error counters |
| err_passive | output | 1 | Engine behaves as error passive |
| rx_valid_irq | output | 1 | Qualified receive-done pulse |
| tx_done_irq | output | 1 | Qualified transmit-done pulse |
| bit0_err | output | 1 | Silent-mode unacknowledged-frame flag |
| pe_clk_en | output | 1 | Protocol sub-block clock enable |
| mb_clk_en | output | 1 | Buffer sub-block clock enable |
| dis_ack | output | 1 | Clocks gated for module-off |
| stop_ack | output | 1 | Stop reached, global clocks may stop |

## Verification
The pin and bit routing is combinational, so it is checked in the same cycle once the synchronizer has settled two edges after a pin change. Interrupt and error pulses are registered and are sampled one cycle after their strobe. Module-off and stop entry move one cycle after the boundary cycle, and the stop acknowledge follows one cycle later. A wake-up needs two synchronizer edges, three counting edges and the state edge, so the stop level is judged four idle cycles after the dominant pulse ends. The bench drives on the falling edge and samples on the falling edge after the edge that moves the result.

// File: rtl/can_mode_pkg.sv
package can_mode_pkg;

  typedef enum logic [1:0] {
    MS_RUN       = 2'd0,
    MS_DIS       = 2'd1,
    MS_STOP_PREP = 2'd2,
    MS_STOP      = 2'd3
  } mode_state_t;

  // Transmit pin level: only a running block in plain mode drives the bus.
  function automatic logic tx_level(input logic run, input logic quiet,
                                    input logic loop, input logic bit_in);
    return (run && !quiet && !loop) ? bit_in : 1'b1;
  endfunction

  // Loop-back takes precedence over silent monitoring.
  function automatic logic quiet_eff(input logic listen, input logic loop);
    return listen && !loop;
  endfunction

endpackage

// File: rtl/can_rx_cond.sv
module can_rx_cond #(
  parameter int SYNC_STAGES = 2,
  parameter int WAKE_LEN    = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic rx_pin,
  output logic rx_sync,
  output logic wake_seen
);
  localparam int CNT_W = $clog2(WAKE_LEN + 1);

  logic [SYNC_STAGES-1:0] sync_q;
  logic [CNT_W-1:0]       dom_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '1;
    else        sync_q <= {sync_q[SYNC_STAGES-2:0], rx_pin};
  end

  assign rx_sync = sync_q[SYNC_STAGES-1];

  // Consecutive dominant samples, saturating at WAKE_LEN.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                             dom_cnt <= '0;
    else if (rx_sync)                       dom_cnt <= '0;
    else if (dom_cnt < CNT_W'(WAKE_LEN))    dom_cnt <= dom_cnt + 1'b1;
  end

  assign wake_seen = (dom_cnt >= CNT_W'(WAKE_LEN));
endmodule

// File: rtl/can_mode_fsm.sv
module can_mode_fsm
  import can_mode_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cfg_listen,
  input  logic        cfg_loop,
  input  logic        cfg_disable,
  input  logic        stop_req,
  input  logic        wake_en,
  input  logic        wake_seen,
  input  logic        boundary,
  output mode_state_t state,
  output logic        mode_listen,
  output logic        mode_loop
);
  mode_state_t nxt;
  logic        stop_blk;
  logic        stop_go;
  logic        woke;

  assign stop_go = stop_req && !stop_blk;
  assign woke    = (state == MS_STOP) && stop_req && wake_en && wake_seen;

  always_comb begin
    nxt = state;
    unique case (state)
      MS_RUN: if (boundary) begin
        if (stop_go)          nxt = MS_STOP_PREP;
        else if (cfg_disable) nxt = MS_DIS;
      end
      MS_DIS: begin
        if (stop_go)           nxt = MS_STOP_PREP;
        else if (!cfg_disable) nxt = MS_RUN;
      end
      MS_STOP_PREP: nxt = stop_req ? MS_STOP : MS_RUN;
      MS_STOP: if (!stop_req || woke) nxt = MS_RUN;
      default: nxt = MS_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state       <= MS_RUN;
      stop_blk    <= 1'b0;
      mode_listen <= 1'b0;
      mode_loop   <= 1'b0;
    end else begin
      state <= nxt;
      if (woke)          stop_blk <= 1'b1;
      else if (!stop_req) stop_blk <= 1'b0;
      if (state == MS_RUN && boundary) begin
        mode_listen <= cfg_listen;
        mode_loop   <= cfg_loop;
      end
    end
  end
endmodule

// File: rtl/can_frame_qual.sv
module can_frame_qual
  import can_mode_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic mode_listen,
  input  logic mode_loop,
  input  logic eng_tx_bit,
  input  logic rx_sync,
  input  logic eng_ack_slot,
  input  logic eng_rx_ok,
  input  logic eng_tx_ok,
  output logic can_tx_pin,
  output logic eng_rx_bit,
  output logic ack_ignore,
  output logic err_freeze,
  output logic err_passive,
  output logic rx_valid_irq,
  output logic tx_done_irq,
  output logic bit0_err
);
  logic quiet;
  logic ack_dom;

  assign quiet       = quiet_eff(mode_listen, mode_loop);
  assign can_tx_pin  = tx_level(run, quiet, mode_loop, eng_tx_bit);
  assign eng_rx_bit  = mode_loop ? eng_tx_bit : rx_sync;
  assign ack_ignore  = mode_loop;
  assign err_freeze  = run && quiet;
  assign err_passive = run && quiet;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            ack_dom <= 1'b0;
    else if (eng_ack_slot) ack_dom <= !rx_sync;
    else if (eng_rx_ok)    ack_dom <= 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_valid_irq <= 1'b0;
      tx_done_irq  <= 1'b0;
      bit0_err     <= 1'b0;
    end else begin
      rx_valid_irq <= run && eng_rx_ok && (!quiet || ack_dom);
      bit0_err     <= run && eng_rx_ok && quiet && !ack_dom;
      tx_done_irq  <= run && eng_tx_ok && !quiet;
    end
  end
endmodule

// File: rtl/can_mode_ctrl.sv
module can_mode_ctrl
  import can_mode_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int WAKE_LEN    = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cfg_listen,
  input  logic cfg_loop,
  input  logic cfg_disable,
  input  logic stop_req,
  input  logic wake_en,
  input  logic eng_tx_bit,
  input  logic eng_frame_end,
  input  logic eng_bus_idle,
  input  logic eng_ack_slot,
  input  logic eng_rx_ok,
  input  logic eng_tx_ok,
  input  logic can_rx_pin,
  output logic can_tx_pin,
  output logic eng_rx_bit,
  output logic ack_ignore,
  output logic err_freeze,
  output logic err_passive,
  output logic rx_valid_irq,
  output logic tx_done_irq,
  output logic bit0_err,
  output logic pe_clk_en,
  output logic mb_clk_en,
  output logic dis_ack,
  output logic stop_ack
);
  mode_state_t state;
  logic        boundary;
  logic        run;
  logic        mode_listen;
  logic        mode_loop;
  logic        rx_sync;
  logic        wake_seen;

  assign boundary  = eng_bus_idle || eng_frame_end;
  assign run       = (state == MS_RUN);
  assign pe_clk_en = run;
  assign mb_clk_en = run;
  assign dis_ack   = (state == MS_DIS);
  assign stop_ack  = (state == MS_STOP);

  can_rx_cond #(.SYNC_STAGES(SYNC_STAGES), .WAKE_LEN(WAKE_LEN)) i_rx_cond (
    .clk       (clk),
    .rst_n     (rst_n),
    .rx_pin    (can_rx_pin),
    .rx_sync   (rx_sync),
    .wake_seen (wake_seen)
  );

  can_mode_fsm i_fsm (
    .clk         (clk),
    .rst_n       (rst_n),
    .cfg_listen  (cfg_listen),
    .cfg_loop    (cfg_loop),
    .cfg_disable (cfg_disable),
    .stop_req    (stop_req),
    .wake_en     (wake_en),
    .wake_seen   (wake_seen),
    .boundary    (boundary),
    .state       (state),
    .mode_listen (mode_listen),
    .mode_loop   (mode_loop)
  );

  can_frame_qual i_qual (
    .clk          (clk),
    .rst_n        (rst_n),
    .run          (run),
    .mode_listen  (mode_listen),
    .mode_loop    (mode_loop),
    .eng_tx_bit   (eng_tx_bit),
    .rx_sync      (rx_sync),
    .eng_ack_slot (eng_ack_slot),
    .eng_rx_ok    (eng_rx_ok),
    .eng_tx_ok    (eng_tx_ok),
    .can_tx_pin   (can_tx_pin),
    .eng_rx_bit   (eng_rx_bit),
    .ack_ignore   (ack_ignore),
    .err_freeze   (err_freeze),
    .err_passive  (err_passive),
    .rx_valid_irq (rx_valid_irq),
    .tx_done_irq  (tx_done_irq),
    .bit0_err     (bit0_err)
  );
endmodule

// File: rtl/can_mode_ctrl_chk.sv
module can_mode_ctrl_chk (
  input logic clk,
  input logic rst_n,
  input logic boundary,
  input logic mode_loop,
  input logic wake_seen,
  input logic wake_en,
  input logic stop_req,
  input logic eng_tx_bit,
  input logic eng_rx_bit,
  input logic can_tx_pin,
  input logic err_freeze,
  input logic rx_valid_irq,
  input logic bit0_err,
  input logic pe_clk_en,
  input logic mb_clk_en,
  input logic dis_ack,
  input logic stop_ack
);
  a_r1_silent_tx_recessive: assert property (@(posedge clk) disable iff (!rst_n)
    err_freeze |-> can_tx_pin);

  a_r2_ack_outcome_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(rx_valid_irq && bit0_err));

  a_r3_loop_route: assert property (@(posedge clk) disable iff (!rst_n)
    mode_loop |-> (eng_rx_bit == eng_tx_bit));

  a_r6_dis_gates_clocks: assert property (@(posedge clk) disable iff (!rst_n)
    dis_ack |-> (!pe_clk_en && !mb_clk_en));

  a_r7_ack_after_gate: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stop_ack) |-> $past(!pe_clk_en));

  a_r8_stop_exit_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(stop_ack) |-> ($past(!stop_req) || $past(wake_en && wake_seen)));

  a_r10_entry_at_boundary: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pe_clk_en) |-> $past(boundary));

  a_r11_gated_tx_recessive: assert property (@(posedge clk) disable iff (!rst_n)
    !pe_clk_en |-> can_tx_pin);
endmodule

bind can_mode_ctrl can_mode_ctrl_chk i_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .boundary     (boundary),
  .mode_loop    (mode_loop),
  .wake_seen    (wake_seen),
  .wake_en      (wake_en),
  .stop_req     (stop_req),
  .eng_tx_bit   (eng_tx_bit),
  .eng_rx_bit   (eng_rx_bit),
  .can_tx_pin   (can_tx_pin),
  .err_freeze   (err_freeze),
  .rx_valid_irq (rx_valid_irq),
  .bit0_err     (bit0_err),
  .pe_clk_en    (pe_clk_en),
  .mb_clk_en    (mb_clk_en),
  .dis_ack      (dis_ack),
  .stop_ack     (stop_ack)
);

// File: tb/test_can_mode_ctrl.sv
`timescale 1ns/1ps
module test_can_mode_ctrl;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_listen = 0, cfg_loop = 0, cfg_disable = 0, stop_req = 0, wake_en = 0;
  logic eng_tx_bit = 1, eng_frame_end = 0, eng_bus_idle = 0, eng_ack_slot = 0;
  logic eng_rx_ok = 0, eng_tx_ok = 0, can_rx_pin = 1;
  logic can_tx_pin, eng_rx_bit, ack_ignore, err_freeze, err_passive;
  logic rx_valid_irq, tx_done_irq, bit0_err, pe_clk_en, mb_clk_en, dis_ack, stop_ack;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  can_mode_ctrl i_can_mode_ctrl (.*);

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(input string req, input string what, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0b expected %0b", req, what, act, exp);
    end
  endtask

  task automatic set_mode(input logic l, input logic lp);
    cfg_listen = l;
    cfg_loop   = lp;
    eng_bus_idle = 1;
    tick();
    eng_bus_idle = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R12 reset state
    chk("R12", "pe_clk_en", pe_clk_en, 1);
    chk("R12", "mb_clk_en", mb_clk_en, 1);
    chk("R12", "dis_ack", dis_ack, 0);
    chk("R12", "stop_ack", stop_ack, 0);
    chk("R12", "rx_valid_irq", rx_valid_irq, 0);
    chk("R12", "tx_done_irq", tx_done_irq, 0);
    chk("R12", "bit0_err", bit0_err, 0);
    eng_tx_bit = 0;
    #1 chk("R12", "normal tx pin", can_tx_pin, 0);
    eng_tx_bit = 1;

    // R1 R3 R5 R11: routing sweep over all mode combinations and levels
    for (int m = 0; m < 4; m++) begin
      logic l, lp, q;
      l = m[0]; lp = m[1]; q = l & ~lp;
      set_mode(l, lp);
      for (int v = 0; v < 4; v++) begin
        eng_tx_bit = v[0];
        can_rx_pin = v[1];
        tick(); tick();
        chk(lp ? "R3" : (l ? "R1" : "R5"), "tx pin", can_tx_pin, (l | lp) ? 1'b1 : v[0]);
        chk(lp ? "R3" : "R5", "rx bit", eng_rx_bit, lp ? v[0] : v[1]);
        chk((l & lp) ? "R11" : "R1", "err_freeze", err_freeze, q);
        chk("R1", "err_passive", err_passive, q);
        chk(lp ? "R3" : "R5", "ack_ignore", ack_ignore, lp);
      end
      // R2 R4: ACK-slot qualification of interrupts
      for (int a = 0; a < 2; a++) begin
        can_rx_pin = a[0] ? 1'b0 : 1'b1;
        tick(); tick(); tick();
        eng_ack_slot = 1;
        tick();
        eng_ack_slot = 0;
        can_rx_pin = 1;
        eng_rx_ok = 1;
        eng_tx_ok = 1;
        tick();
        eng_rx_ok = 0;
        eng_tx_ok = 0;
        chk(q ? "R2" : "R4", "rx_valid_irq", rx_valid_irq, q ? a[0] : 1'b1);
        chk("R2", "bit0_err", bit0_err, q & ~a[0]);
        chk(q ? "R1" : "R4", "tx_done_irq", tx_done_irq, ~q);
        tick();
      end
    end
    eng_tx_bit = 1;
    can_rx_pin = 1;

    // R10: mode change mid-frame is held until frame end
    set_mode(0, 0);
    cfg_listen = 1;
    tick(); tick();
    eng_tx_bit = 0;
    #1 chk("R10", "tx pin mid-frame", can_tx_pin, 0);
    eng_frame_end = 1;
    tick();
    eng_frame_end = 0;
    chk("R10", "tx pin after frame end", can_tx_pin, 1);
    set_mode(0, 0);

    // R6 R10 R11: module-off
    cfg_disable = 1;
    tick(); tick();
    chk("R10", "pe_clk_en mid-frame", pe_clk_en, 1);
    eng_bus_idle = 1;
    tick();
    eng_bus_idle = 0;
    chk("R6", "pe_clk_en", pe_clk_en, 0);
    chk("R6", "mb_clk_en", mb_clk_en, 0);
    chk("R6", "dis_ack", dis_ack, 1);
    chk("R11", "tx pin gated", can_tx_pin, 1);
    eng_rx_ok = 1;
    tick();
    eng_rx_ok = 0;
    chk("R6", "no irq while gated", rx_valid_irq, 0);
    cfg_disable = 0;
    tick();
    chk("R6", "pe_clk_en restored", pe_clk_en, 1);
    chk("R6", "dis_ack cleared", dis_ack, 0);
    eng_tx_bit = 1;

    // R7: stop handshake
    stop_req = 1;
    eng_bus_idle = 1;
    tick();
    chk("R7", "pe_clk_en in prep", pe_clk_en, 0);
    chk("R7", "stop_ack in prep", stop_ack, 0);
    tick();
    chk("R7", "stop_ack", stop_ack, 1);
    stop_req = 0;
    tick();
    eng_bus_idle = 0;
    chk("R7", "pe_clk_en after release", pe_clk_en, 1);
    chk("R7", "stop_ack after release", stop_ack, 0);

    // R8 R9: wake-up filter sweep
    for (int en = 0; en < 2; en++) begin
      for (int len = 1; len <= 5; len++) begin
        logic woke_exp;
        woke_exp = (en == 1) && (len >= 3);
        stop_req = 1;
        eng_bus_idle = 1;
        tick(); tick();
        eng_bus_idle = 0;
        chk("R7", "in stop", stop_ack, 1);
        wake_en = en[0];
        can_rx_pin = 0;
        repeat (len) tick();
        can_rx_pin = 1;
        repeat (4) tick();
        chk("R8", "stop_ack after pulse", stop_ack, ~woke_exp);
        if (woke_exp) begin
          eng_bus_idle = 1;
          tick(); tick();
          chk("R9", "no re-entry", stop_ack, 0);
          chk("R9", "clocks stay on", pe_clk_en, 1);
        end
        stop_req = 0;
        eng_bus_idle = 0;
        tick(); tick();
        wake_en = 0;
      end
    end
    // R9: drop then raise re-enters
    stop_req = 1;
    eng_bus_idle = 1;
    tick(); tick();
    chk("R9", "re-entry after drop", stop_ack, 1);
    stop_req = 0;
    tick();
    eng_bus_idle = 0;

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule